// File: doc/BRIEF.md
# Prescaled Timer With Match Actions

This block is a free-running up-counter fed by a programmable prescaler, with four match channels that watch the count. The prescaler counts enabled clocks up to a programmable limit. At each wrap it issues one count step. Every match channel holds a compare value and three action bits. When the count steps while it equals the compare value, the channel can raise a sticky interrupt flag, return the count to zero, and halt counting.

Each channel also has a shadow compare value. When its reload bit is set, the shadow is copied into the live compare value every time the count is forced back to zero. That happens either by a match clear or by the software hold-clear bit. Software can therefore change a period safely while the timer runs. A plain register port controls everything. It has a write strobe with address and data, and a combinational read path.

Top module: `prescaled_match_timer`

## Requirements
- R1: The prescale count runs 0,1,...,limit. The count steps by one only on the clock where the prescale count equals the limit. That clock also returns the prescale count to 0. A limit of L gives one count step every L+1 enabled clocks.
- R2: While the run bit (CTRL bit 0) is 0, neither the count nor the prescale count changes, unless software writes them.
- R3: While the hold-clear bit (CTRL bit 1) is 1, the count and the prescale count read 0 from the next clock onward. Software writes to them have no effect during that time.
- R4: A channel matches only on a step clock where the count equals its compare value. If its interrupt action (ACTIONS bit 3n) is set, flag n becomes 1 after that clock. It is not set on the clocks where the count merely sits at that value.
- R5: With its clear action (ACTIONS bit 3n+1) set, a match makes the next count value 0 instead of compare+1.
- R6: With its stop action (ACTIONS bit 3n+2) set, a match clears the run bit. The count stays at the compare value and the prescale count becomes 0.
- R7: With reload enabled (ACTIONS bit 24+n), compare n is loaded from shadow n whenever the count is forced to zero by a match clear or by hold-clear. At no other time does the shadow reach the compare value.
- R8: Flags occupy FLAGS bits 0..3. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. A new match on the same clock wins over the clear.
- R9: The irq output is 1 exactly while any flag is 1.
- R10: A software write to the count in the same clock as a match clear sets the count to the written value.
- R11: The register addresses are CTRL 0x0, LIMIT 0x1, PRESCALE 0x2, COUNT 0x3, ACTIONS 0x4, FLAGS 0x5, COMPARE n at 0x8+n and SHADOW n at 0xC+n. All of them reset to 0. ACTIONS reads back only its defined bits (0x0F000FFF for four channels).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | W | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | W | Read data for rd_addr (combinational) |
| irq | output | 1 | Level interrupt, high while any flag is set |

## Verification
The counting path is tried with prescale limits of 0, 1 and 3. This separates a step every clock from a step every second and every fourth clock, and it catches off-by-one errors in the wrap compare. Each match action is exercised on its own channel. An interrupt-only match shows that the count runs on past the compare value. A clear match shows the zero return. A stop match shows the count parked with the run bit dropped. Reload is driven once through hold-clear and once through a match clear, and the bench checks that writing a shadow alone does not reach the compare value. Two back-to-back count writes place a software write on the exact clock of a match clear, to show which one wins.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

   localparam int unsigned ADDR_W     = 4;
   localparam int unsigned MAX_CH     = 4;
   localparam int unsigned RELOAD_LSB = 24;

   localparam logic [ADDR_W-1:0] A_CTRL     = 4'h0;
   localparam logic [ADDR_W-1:0] A_LIMIT    = 4'h1;
   localparam logic [ADDR_W-1:0] A_PRESCALE = 4'h2;
   localparam logic [ADDR_W-1:0] A_COUNT    = 4'h3;
   localparam logic [ADDR_W-1:0] A_ACTIONS  = 4'h4;
   localparam logic [ADDR_W-1:0] A_FLAGS    = 4'h5;
   localparam logic [ADDR_W-1:0] A_COMPARE  = 4'h8;
   localparam logic [ADDR_W-1:0] A_SHADOW   = 4'hC;

   // per-channel action triple, LSB first as laid out in ACTIONS
   typedef struct packed {
      logic stop;
      logic clear;
      logic irq;
   } chan_act_t;

   function automatic logic [63:0] act_mask(input int unsigned nch);
      logic [63:0] m = '0;
      for (int unsigned n = 0; n < nch; n++) begin
         m[3*n +: 3]        = 3'b111;
         m[RELOAD_LSB + n]  = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/pmt_count_core.sv
module pmt_count_core #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         hold_clr,
   input  logic [W-1:0] psc_lim,
   input  logic         psc_wr,
   input  logic         count_wr,
   input  logic [W-1:0] wr_data,
   input  logic         clr_hit,
   input  logic         stop_hit,
   output logic         tick,
   output logic [W-1:0] psc_cnt,
   output logic [W-1:0] count
);

   logic         step;
   logic [W-1:0] psc_q, count_q;

   assign step    = run & ~hold_clr;
   assign tick    = step & (psc_q == psc_lim);
   assign psc_cnt = psc_q;
   assign count   = count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psc_q   <= '0;
         count_q <= '0;
      end else begin
         if (hold_clr)      psc_q <= '0;
         else if (psc_wr)   psc_q <= wr_data;
         else if (tick)     psc_q <= '0;
         else if (step)     psc_q <= psc_q + 1'b1;

         if (hold_clr)      count_q <= '0;
         else if (count_wr) count_q <= wr_data;
         else if (clr_hit)  count_q <= '0;
         else if (tick && !stop_hit) count_q <= count_q + 1'b1;
      end
   end

   assert_hold_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hold_clr |=> (count_q == '0 && psc_q == '0));

   assert_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !hold_clr && !psc_wr && !count_wr) |=> ($stable(count_q) && $stable(psc_q)));

   assert_step_only_on_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !hold_clr && !count_wr) |=> $stable(count_q));

endmodule

// File: rtl/pmt_match_chan.sv
module pmt_match_chan
   import pmt_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [W-1:0] count,
   input  chan_act_t    act,
   input  logic         reload_en,
   input  logic         reload_evt,
   input  logic         cmp_wr,
   input  logic         shd_wr,
   input  logic [W-1:0] wr_data,
   output logic         hit_irq,
   output logic         hit_clr,
   output logic         hit_stop,
   output logic [W-1:0] cmp_val,
   output logic [W-1:0] shd_val
);

   logic [W-1:0] cmp_q, shd_q;
   logic         hit;

   assign hit      = tick & (count == cmp_q);
   assign hit_irq  = hit & act.irq;
   assign hit_clr  = hit & act.clear;
   assign hit_stop = hit & act.stop;
   assign cmp_val  = cmp_q;
   assign shd_val  = shd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '0;
         shd_q <= '0;
      end else begin
         if (shd_wr) shd_q <= wr_data;
         if (cmp_wr)                       cmp_q <= wr_data;
         else if (reload_evt && reload_en) cmp_q <= shd_q;
      end
   end

   assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reload_evt && reload_en && !cmp_wr) |=> (cmp_q == $past(shd_q)));

   assert_no_stray_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!reload_evt && !cmp_wr) |=> $stable(cmp_q));

endmodule

// File: rtl/pmt_flag_bank.sv
module pmt_flag_bank #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flags,
   output logic         irq
);

   logic [N-1:0] flags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (flags_q & ~clr) | set;
   end

   assign flags = flags_q;
   assign irq   = |flags_q;

   assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|set) |=> ((flags_q & $past(set)) == $past(set)));

   assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr & ~set)) |=> ((flags_q & $past(clr & ~set)) == '0));

endmodule

// File: rtl/prescaled_match_timer.sv
module prescaled_match_timer
   import pmt_pkg::*;
#(
   parameter int unsigned W      = 32,
   parameter int unsigned NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [W-1:0]      wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [W-1:0]      rd_data,
   output logic              irq
);

   localparam logic [W-1:0] ACT_MASK = W'(act_mask(NUM_CH));

   if (W < 28 || W > 64) begin : g_bad_width
      $error("prescaled_match_timer: W must lie in 28..64");
   end
   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_chans
      $error("prescaled_match_timer: NUM_CH must lie in 1..4");
   end

   logic              run_q, hold_q;
   logic [W-1:0]      lim_q, act_q;
   logic              ctrl_wr, lim_wr, psc_wr, count_wr, act_wr, flags_wr;
   logic              tick, reload_evt;
   logic [W-1:0]      psc_cnt, count;
   logic [NUM_CH-1:0] h_irq, h_clr, h_stop, flags, clr_vec;
   logic [W-1:0]      cmp_vals [NUM_CH];
   logic [W-1:0]      shd_vals [NUM_CH];

   assign ctrl_wr  = wr_en && (wr_addr == A_CTRL);
   assign lim_wr   = wr_en && (wr_addr == A_LIMIT);
   assign psc_wr   = wr_en && (wr_addr == A_PRESCALE);
   assign count_wr = wr_en && (wr_addr == A_COUNT);
   assign act_wr   = wr_en && (wr_addr == A_ACTIONS);
   assign flags_wr = wr_en && (wr_addr == A_FLAGS);
   assign clr_vec  = flags_wr ? wr_data[NUM_CH-1:0] : '0;

   // zero return by hold-clear, or by a match clear that software did not override
   assign reload_evt = hold_q | ((|h_clr) & ~count_wr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         hold_q <= 1'b0;
         lim_q  <= '0;
         act_q  <= '0;
      end else begin
         if (ctrl_wr) begin
            run_q  <= wr_data[0];
            hold_q <= wr_data[1];
         end else if (|h_stop) begin
            run_q  <= 1'b0;
         end
         if (lim_wr) lim_q <= wr_data;
         if (act_wr) act_q <= wr_data & ACT_MASK;
      end
   end

   pmt_count_core #(.W(W)) i_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_q),
      .hold_clr (hold_q),
      .psc_lim  (lim_q),
      .psc_wr   (psc_wr),
      .count_wr (count_wr),
      .wr_data  (wr_data),
      .clr_hit  (|h_clr),
      .stop_hit (|h_stop),
      .tick     (tick),
      .psc_cnt  (psc_cnt),
      .count    (count)
   );

   for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
      localparam logic [ADDR_W-1:0] CMP_ADDR = A_COMPARE + 4'(n);
      localparam logic [ADDR_W-1:0] SHD_ADDR = A_SHADOW + 4'(n);
      chan_act_t act;
      assign act = act_q[3*n +: 3];

      pmt_match_chan #(.W(W)) i_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .tick       (tick),
         .count      (count),
         .act        (act),
         .reload_en  (act_q[RELOAD_LSB + n]),
         .reload_evt (reload_evt),
         .cmp_wr     (wr_en && (wr_addr == CMP_ADDR)),
         .shd_wr     (wr_en && (wr_addr == SHD_ADDR)),
         .wr_data    (wr_data),
         .hit_irq    (h_irq[n]),
         .hit_clr    (h_clr[n]),
         .hit_stop   (h_stop[n]),
         .cmp_val    (cmp_vals[n]),
         .shd_val    (shd_vals[n])
      );
   end

   pmt_flag_bank #(.N(NUM_CH)) i_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (h_irq),
      .clr   (clr_vec),
      .flags (flags),
      .irq   (irq)
   );

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_CTRL:     rd_data = W'({hold_q, run_q});
         A_LIMIT:    rd_data = lim_q;
         A_PRESCALE: rd_data = psc_cnt;
         A_COUNT:    rd_data = count;
         A_ACTIONS:  rd_data = act_q;
         A_FLAGS:    rd_data = W'(flags);
         default:    rd_data = '0;
      endcase
      for (int n = 0; n < NUM_CH; n++) begin
         if (rd_addr == A_COMPARE + 4'(n)) rd_data = cmp_vals[n];
         if (rd_addr == A_SHADOW + 4'(n))  rd_data = shd_vals[n];
      end
   end

   assert_stop_drops_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((|h_stop) && !ctrl_wr) |=> !run_q);

   assert_sw_count_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (count_wr && !hold_q) |=> (count == $past(wr_data)));

   assert_irq_tracks_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flags == '0) |-> !irq);

endmodule

// File: tb/test_prescaled_match_timer.sv
`timescale 1ns/1ps
module test_prescaled_match_timer;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [3:0]   wr_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic [3:0]   rd_addr = '0;
   logic [W-1:0] rd_data;
   logic         irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   localparam logic [3:0] CTRL = 4'h0, LIMIT = 4'h1, PSC = 4'h2, COUNT = 4'h3,
                          ACTS = 4'h4, FLAGS = 4'h5, CMP = 4'h8, SHD = 4'hC;

   always #4 clk = ~clk;

   prescaled_match_timer #(.W(W), .NUM_CH(4)) i_prescaled_match_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
   );

   // all tasks start and end at a falling edge
   task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [3:0] a, input logic [W-1:0] exp);
      logic [W-1:0] got;
      rd_addr = a; #1; got = rd_data;
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s addr 0x%0h: actual 0x%0h expected 0x%0h", req, a, got, exp);
      end
   endtask

   task automatic chk_irq(input string req, input logic exp);
      checks++;
      if (irq !== exp) begin
         errors++;
         $display("FAIL %s irq: actual %0b expected %0b", req, irq, exp);
      end
   endtask

   task automatic clear_counters();
      wr(CTRL, 32'h2); wr(CTRL, 32'h0);
   endtask

   task automatic t_reset_and_map();
      chk("R11", CTRL, 0); chk("R11", COUNT, 0); chk("R11", PSC, 0);
      chk("R11", FLAGS, 0); chk("R11", CMP + 4'd2, 0); chk_irq("R9", 1'b0);
      wr(ACTS, 32'hFFFF_FFFF); chk("R11", ACTS, 32'h0F00_0FFF);
      wr(ACTS, 32'h0);
      wr(SHD + 4'd3, 32'h1234); chk("R11", SHD + 4'd3, 32'h1234);
      chk("R7", CMP + 4'd3, 32'h0); // shadow write alone reaches no compare
   endtask

   task automatic t_prescale();
      wr(LIMIT, 2); wr(CTRL, 1);
      wait_clk(9);  chk("R1", COUNT, 3); chk("R1", PSC, 0);
      wait_clk(1);  chk("R1", PSC, 1);   chk("R1", COUNT, 3);
   endtask

   task automatic t_freeze();
      logic [W-1:0] c, p;
      wr(CTRL, 0);
      rd_addr = COUNT; #1; c = rd_data;
      rd_addr = PSC;   #1; p = rd_data;
      wait_clk(5);
      chk("R2", COUNT, c); chk("R2", PSC, p);
   endtask

   task automatic t_hold();
      wr(CTRL, 3);
      wait_clk(1); chk("R3", COUNT, 0); chk("R3", PSC, 0);
      wr(COUNT, 55); chk("R3", COUNT, 0);
      wr(CTRL, 0);  chk("R3", COUNT, 0);
   endtask

   task automatic t_interrupt();
      wr(LIMIT, 3); wr(CMP + 4'd0, 5); wr(ACTS, 32'h1); wr(CTRL, 1);
      wait_clk(23); chk("R4", COUNT, 5); chk("R4", FLAGS, 0); chk_irq("R9", 1'b0);
      wait_clk(1);  chk("R4", COUNT, 6); chk("R4", FLAGS, 1); chk_irq("R9", 1'b1);
      wr(CTRL, 0);
      wr(FLAGS, 0); chk("R8", FLAGS, 1);
      wr(FLAGS, 1); chk("R8", FLAGS, 0); chk_irq("R9", 1'b0);
   endtask

   task automatic t_clear_action();
      clear_counters();
      wr(LIMIT, 0); wr(CMP + 4'd1, 3); wr(ACTS, 32'h18); wr(CTRL, 1);
      wait_clk(3); chk("R5", COUNT, 3);
      wait_clk(1); chk("R5", COUNT, 0); chk("R4", FLAGS, 32'h2);
      wait_clk(2); chk("R5", COUNT, 2);
      wr(CTRL, 2); wr(FLAGS, 32'hF);
   endtask

   task automatic t_reload();
      // hold-clear still set from the previous scenario
      wr(SHD + 4'd1, 6); wr(ACTS, 32'h18 | (32'h1 << 25));
      wait_clk(1); chk("R7", CMP + 4'd1, 6);
      wr(SHD + 4'd1, 2); wait_clk(1); chk("R7", CMP + 4'd1, 2);
      wr(CTRL, 0);
      wr(SHD + 4'd1, 4); wait_clk(2); chk("R7", CMP + 4'd1, 2);
      wr(CTRL, 1);
      wait_clk(2); chk("R5", COUNT, 2);
      wait_clk(1); chk("R7", COUNT, 0); chk("R7", CMP + 4'd1, 4);
      wait_clk(4); chk("R7", COUNT, 4);
      wait_clk(1); chk("R7", COUNT, 0);
      wr(CTRL, 2); wr(CTRL, 0); wr(FLAGS, 32'hF);
   endtask

   task automatic t_stop();
      wr(ACTS, 32'h100); wr(CMP + 4'd2, 4); wr(LIMIT, 1); wr(CTRL, 1);
      wait_clk(9);  chk("R6", COUNT, 4); chk("R6", PSC, 1); chk("R6", CTRL, 1);
      wait_clk(3);  chk("R6", COUNT, 4); chk("R6", PSC, 0); chk("R6", CTRL, 0);
      chk("R4", FLAGS, 0);
   endtask

   task automatic t_priority();
      clear_counters();
      wr(LIMIT, 0); wr(CMP + 4'd3, 7); wr(ACTS, 32'h400); wr(CTRL, 1);
      wr(COUNT, 7); wr(COUNT, 9);
      chk("R10", COUNT, 9);
      wait_clk(1); chk("R10", COUNT, 10);
      wr(COUNT, 6); wait_clk(1); chk("R5", COUNT, 7);
      wait_clk(1); chk("R5", COUNT, 0);
      wr(CTRL, 0);
   endtask

   initial begin
      #200000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_and_map();
      t_prescale();
      t_freeze();
      t_hold();
      t_interrupt();
      t_clear_action();
      t_reload();
      t_stop();
      t_priority();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule